// File: doc/BRIEF.md
# Priority External Interrupt Controller

This block gathers up to 63 external interrupt lines and turns them into one interrupt request for a processor core. Each line first passes a gateway: two synchronizer flops, a polarity inversion, then either a level path (pending copies the corrected input) or an edge path (pending is held from an active edge until software clears it). A pending line that is also enabled competes on its 4-bit priority. The strongest competitor raises the request when it ranks strictly above both the global threshold and the level of the handler already running.

Software reaches everything over a simple 32-bit register bus. Reads are combinational from the address. Writes take effect at the clock edge while `bus_valid` and `bus_write` are high. Writing the capture register freezes the current arbitration winner. Its ID then appears inside a handler-address word, beneath a vector-table base that software programs, and its priority sits in a separate claim register.

Each edge gateway runs a two-state machine. In `GW_IDLE`, an active edge seen in edge mode takes the transition `latch` to `GW_HELD`. In `GW_HELD`, a gateway-clear write takes the transition `release` back to `GW_IDLE`, unless a new active edge arrives in the same cycle, in which case it stays in `GW_HELD`.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, `irq_req` is low and every register reads zero.
- R2: The per-source registers sit at byte offset s*4 in three pages: 0x0000 holds priority bits [3:0], 0x2000 holds the enable in bit 0, and 0x4000 holds the gateway setup in bits [1:0]. The global order bit is bit 0 of 0x3000. All of these read back what was written, masked to their width.
- R3: In level mode (gateway bit1=0), bit 0 of 0x1000+s*4 shows the synchronized input after polarity correction. Writes to the pending page change nothing.
- R4: Gateway bit 0 set to 1 makes the source active-low. Set to 0, it is active-high.
- R5: In edge mode (gateway bit1=1), an active edge sets pending. Pending stays set after the input goes inactive, and any write to 0x5000+s*4 clears it.
- R6: A source whose enable bit is 0 never wins arbitration and never causes a request.
- R7: With order bit 0 the highest priority value wins (15 strongest). With order bit 1 the lowest value wins (0 strongest).
- R8: When two competitors share the strongest priority, the lower source ID wins.
- R9: `irq_req` is high exactly when a winner exists and its priority ranks strictly above both the threshold at 0x3004[3:0] and the current level at 0x3008[3:0], under the active ordering.
- R10: Any write to 0x300C captures the winner. Its ID goes to bits [9:2] of 0x3010 and its priority to 0x3014[3:0]. With no competitor both captured values are 0. Both hold until the next capture.
- R11: Bits [31:10] of 0x3010 are a writable table base. Writes to bits [9:0] of that word are ignored, and bits [1:0] read zero.
- R12: Unused offsets, including source index 0 and indices above 63, read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_src | input | 63 | External lines, bit s is source s |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
Directed patterns put two equal-priority sources against each other, which distinguishes a lowest-ID tie-break from a highest-ID one. A disabled source is given a stronger priority than an enabled one, which shows whether the enable actually gates arbitration. The order bit is flipped with the same sources in place, so a design that ignores the reversal loses. The threshold and current level are set equal to the winner's priority, which separates a strict comparison from a non-strict one. Random rounds then mix gateway polarity and trigger changes, input toggles, clears and global settings, and compare both the request line and a capture against a bench model after every round.

// File: rtl/eic_pkg.sv
package eic_pkg;
    localparam int PRIO_W = 4;
    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic {GW_IDLE, GW_HELD} gw_state_e;

    localparam logic [3:0] PG_PRIO = 4'h0;
    localparam logic [3:0] PG_PEND = 4'h1;
    localparam logic [3:0] PG_EN   = 4'h2;
    localparam logic [3:0] PG_GLB  = 4'h3;
    localparam logic [3:0] PG_GW   = 4'h4;
    localparam logic [3:0] PG_CLR  = 4'h5;

    localparam logic [11:0] G_ORDER = 12'h000;
    localparam logic [11:0] G_THR   = 12'h004;
    localparam logic [11:0] G_CUR   = 12'h008;
    localparam logic [11:0] G_CAP   = 12'h00C;
    localparam logic [11:0] G_HAND  = 12'h010;
    localparam logic [11:0] G_CLAIM = 12'h014;

    // Strength of a priority under the selected ordering: larger is stronger.
    function automatic prio_t rank_of(input prio_t p, input logic rev);
        return rev ? ~p : p;
    endfunction
endpackage

// File: rtl/eic_gateway.sv
module eic_gateway
    import eic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic active_low,
    input  logic edge_mode,
    input  logic clr,
    output logic pending
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic active, act_d_q, rise;
    gw_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '0;
            act_d_q <= 1'b0;
        end else begin
            sync_q  <= {sync_q[SYNC_STAGES-2:0], raw_in};
            act_d_q <= active;
        end
    end

    assign active = sync_q[SYNC_STAGES-1] ^ active_low;
    assign rise   = edge_mode & active & ~act_d_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GW_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_IDLE: if (rise)         state_d = GW_HELD;
            GW_HELD: if (clr && !rise) state_d = GW_IDLE;
            default:                   state_d = GW_IDLE;
        endcase
    end

    always_comb begin
        pending = edge_mode ? (state_q == GW_HELD) : active;
    end
endmodule

// File: rtl/eic_arbiter.sv
module eic_arbiter
    import eic_pkg::*;
#(
    parameter int NUM_SRC = 63,
    parameter int SRC_W   = 6
) (
    input  prio_t             prio [NUM_SRC+1],
    input  logic [NUM_SRC:0]  req,
    input  logic              rev,
    output logic              win_valid,
    output logic [SRC_W-1:0]  win_id,
    output prio_t             win_prio
);
    // Scan from the top ID down; ">=" lets a lower ID take over on a tie.
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        win_prio  = '0;
        for (int i = NUM_SRC; i >= 0; i--) begin
            if (req[i] && (!win_valid ||
                rank_of(prio[i], rev) >= rank_of(win_prio, rev))) begin
                win_valid = 1'b1;
                win_id    = SRC_W'(i);
                win_prio  = prio[i];
            end
        end
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eic_pkg::*;
#(
    parameter int NUM_SRC     = 63,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [15:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC:1]   irq_src,
    output logic               irq_req
);
    localparam int SRC_W = $clog2(NUM_SRC + 1);

    logic [3:0]       page;
    logic [11:0]      off;
    logic [7:0]       idx8;
    logic [SRC_W-1:0] idx;
    logic             src_hit, wr_en, cap_stb;

    prio_t            prio_q [NUM_SRC+1];
    logic [NUM_SRC:0] en_q, pol_q, typ_q, pend_v, clr_v;
    logic             order_q;
    prio_t            thr_q, cur_q, claim_prio, win_prio;
    logic [21:0]      base_q;
    logic [SRC_W-1:0] claim_id, win_id;
    logic             win_valid;
    logic             unused_wdata;

    assign page    = bus_addr[15:12];
    assign off     = bus_addr[11:0];
    assign idx8    = off[9:2];
    assign idx     = idx8[SRC_W-1:0];
    assign wr_en   = bus_valid & bus_write;
    assign src_hit = (off[11:10] == 2'b00) && (off[1:0] == 2'b00) &&
                     (idx8 != 8'd0) && (32'(idx8) <= 32'(NUM_SRC));
    assign cap_stb = wr_en && (page == PG_GLB) && (off == G_CAP);
    assign unused_wdata = ^bus_wdata[9:PRIO_W];

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= NUM_SRC; i++) prio_q[i] <= '0;
            en_q    <= '0;
            pol_q   <= '0;
            typ_q   <= '0;
            order_q <= 1'b0;
            thr_q   <= '0;
            cur_q   <= '0;
            base_q  <= '0;
        end else if (wr_en) begin
            if (src_hit) begin
                unique case (page)
                    PG_PRIO: prio_q[idx] <= bus_wdata[PRIO_W-1:0];
                    PG_EN:   en_q[idx]   <= bus_wdata[0];
                    PG_GW: begin
                        pol_q[idx] <= bus_wdata[0];
                        typ_q[idx] <= bus_wdata[1];
                    end
                    default: ;
                endcase
            end
            if (page == PG_GLB) begin
                unique case (off)
                    G_ORDER: order_q <= bus_wdata[0];
                    G_THR:   thr_q   <= bus_wdata[PRIO_W-1:0];
                    G_CUR:   cur_q   <= bus_wdata[PRIO_W-1:0];
                    G_HAND:  base_q  <= bus_wdata[31:10];
                    default: ;
                endcase
            end
        end
    end

    // Gateways, one per source; slot 0 is permanently idle
    assign pend_v[0] = 1'b0;
    assign clr_v[0]  = 1'b0;
    for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
        assign clr_v[s] = wr_en && src_hit && (page == PG_CLR) &&
                          (idx == SRC_W'(s));
        eic_gateway #(.SYNC_STAGES(SYNC_STAGES)) u_gw (
            .clk        (clk),
            .rst_n      (rst_n),
            .raw_in     (irq_src[s]),
            .active_low (pol_q[s]),
            .edge_mode  (typ_q[s]),
            .clr        (clr_v[s]),
            .pending    (pend_v[s])
        );
    end

    eic_arbiter #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_arb (
        .prio      (prio_q),
        .req       (pend_v & en_q),
        .rev       (order_q),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_prio  (win_prio)
    );

    assign irq_req = win_valid &&
                     (rank_of(win_prio, order_q) > rank_of(thr_q, order_q)) &&
                     (rank_of(win_prio, order_q) > rank_of(cur_q, order_q));

    // Capture of the winner
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            claim_id   <= '0;
            claim_prio <= '0;
        end else if (cap_stb) begin
            claim_id   <= win_valid ? win_id : '0;
            claim_prio <= win_valid ? win_prio : '0;
        end
    end

    // Read path
    always_comb begin
        bus_rdata = '0;
        if (src_hit) begin
            unique case (page)
                PG_PRIO: bus_rdata = 32'(prio_q[idx]);
                PG_PEND: bus_rdata = 32'(pend_v[idx]);
                PG_EN:   bus_rdata = 32'(en_q[idx]);
                PG_GW:   bus_rdata = 32'({typ_q[idx], pol_q[idx]});
                default: ;
            endcase
        end
        if (page == PG_GLB) begin
            unique case (off)
                G_ORDER: bus_rdata = 32'(order_q);
                G_THR:   bus_rdata = 32'(thr_q);
                G_CUR:   bus_rdata = 32'(cur_q);
                G_HAND:  bus_rdata = {base_q, 8'(claim_id), 2'b00};
                G_CLAIM: bus_rdata = 32'(claim_prio);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk #(
    parameter int NUM_SRC = 63,
    parameter int SRC_W   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_write,
    input logic [15:0]      bus_addr,
    input logic             irq_req,
    input logic             win_valid,
    input logic [SRC_W-1:0] win_id,
    input logic [NUM_SRC:0] en_q,
    input logic [NUM_SRC:0] pend_v,
    input logic [SRC_W-1:0] claim_id,
    input logic [3:0]       claim_prio
);
    p_req_has_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> win_valid);

    p_winner_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (en_q[win_id] && pend_v[win_id]));

    p_capture_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write && bus_addr == 16'h300C)
        |=> ($stable(claim_id) && $stable(claim_prio)));

    p_empty_claim_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_id == '0) |-> (claim_prio == 4'd0));
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .irq_req    (irq_req),
    .win_valid  (win_valid),
    .win_id     (win_id),
    .en_q       (en_q),
    .pend_v     (pend_v),
    .claim_id   (claim_id),
    .claim_prio (claim_prio)
);

// File: tb/ext_irq_ctrl_bench.sv
`timescale 1ns/1ps
module ext_irq_ctrl_bench;
    localparam int NS = 63;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NS:1] irq_src = '0;
    logic        irq_req;

    int nchk = 0, nerr = 0;
    bit done = 0;

    int m_prio[64], m_en[64], m_pol[64], m_typ[64], m_in[64], m_lat[64];
    int m_order = 0, m_thr = 0, m_cur = 0, m_base = 0;

    always #2.5 clk = ~clk;

    ext_irq_ctrl u_ext_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_src(irq_src), .irq_req(irq_req)
    );

    function automatic int act(int s);  return m_in[s] ^ m_pol[s]; endfunction
    function automatic int pend(int s); return m_typ[s] ? m_lat[s] : act(s); endfunction
    function automatic int rnk(int p);  return m_order ? 15 - p : p; endfunction
    function automatic int winner();
        int b = 0;
        for (int s = 1; s <= NS; s++)
            if (m_en[s] != 0 && pend(s) != 0 && (b == 0 || rnk(m_prio[s]) > rnk(m_prio[b])))
                b = s;
        return b;
    endfunction
    function automatic int exp_req();
        int w = winner();
        return (w != 0 && rnk(m_prio[w]) > rnk(m_thr) && rnk(m_prio[w]) > rnk(m_cur)) ? 1 : 0;
    endfunction

    task automatic chk(string tag, int a, int e);
        nchk++;
        if (a != e) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
        end
    endtask

    task automatic wr(int addr, int data);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = 16'(addr); bus_wdata = data;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(int addr, output int data);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = 16'(addr);
        #1 data = bus_rdata;
        bus_valid = 0;
    endtask

    task automatic settle(); repeat (6) @(negedge clk); endtask

    task automatic set_in(int s, int v);
        int old = act(s);
        m_in[s] = v; irq_src[s] = v[0];
        if (m_typ[s] != 0 && old == 0 && act(s) != 0) m_lat[s] = 1;
        settle();
    endtask

    task automatic set_gw(int s, int pol, int typ);
        int old = act(s);
        m_pol[s] = pol; m_typ[s] = typ;
        wr(16'h4000 + s * 4, (typ << 1) | pol);
        if (typ != 0 && old == 0 && act(s) != 0) m_lat[s] = 1;
        settle();
    endtask

    task automatic set_prio(int s, int p); m_prio[s] = p & 15; wr(s * 4, p); endtask
    task automatic set_en(int s, int e);   m_en[s] = e & 1; wr(16'h2000 + s * 4, e); endtask
    task automatic clr(int s);             m_lat[s] = 0; wr(16'h5000 + s * 4, 32'hA5); settle(); endtask

    task automatic check_all(string tag);
        int d, w;
        settle();
        w = winner();
        chk({tag, " R9 irq_req"}, int'(irq_req), exp_req());
        wr(16'h300C, 0);
        rd(16'h3010, d);
        chk({tag, " R10 captured id"}, (d >> 2) & 255, w);
        chk({tag, " R11 base kept"}, d & 32'hFFFFFC03, m_base);
        rd(16'h3014, d);
        chk({tag, " R10 captured prio"}, d, w != 0 ? m_prio[w] : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int d;
        for (int i = 0; i < 64; i++) begin
            m_prio[i] = 0; m_en[i] = 0; m_pol[i] = 0; m_typ[i] = 0; m_in[i] = 0; m_lat[i] = 0;
        end
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        settle();

        // R1: reset state
        chk("R1 irq_req", int'(irq_req), 0);
        rd(16'h0004, d); chk("R1 prio", d, 0);
        rd(16'h2004, d); chk("R1 enable", d, 0);
        rd(16'h4004, d); chk("R1 gateway", d, 0);
        rd(16'h3000, d); chk("R1 order", d, 0);
        rd(16'h3010, d); chk("R1 handler", d, 0);

        // R2: field readback
        set_prio(5, 32'hA7); rd(16'h0014, d); chk("R2 prio", d, 7);
        set_en(5, 32'hFF);   rd(16'h2014, d); chk("R2 enable", d, 1);
        wr(16'h4014, 32'hFF); rd(16'h4014, d); chk("R2 gateway", d, 3);
        wr(16'h4014, 0); settle();
        wr(16'h3000, 32'h3); rd(16'h3000, d); chk("R2 order", d, 1);
        wr(16'h3000, 0);

        // R3: level pending, read-only
        set_in(5, 1); rd(16'h1014, d); chk("R3 level high", d, 1);
        wr(16'h1014, 0); rd(16'h1014, d); chk("R3 pending write ignored", d, 1);
        check_all("R3 level");
        set_in(5, 0); rd(16'h1014, d); chk("R3 level low", d, 0);

        // R4: active-low
        set_gw(6, 1, 0); rd(16'h1018, d); chk("R4 active low idle input", d, 1);
        set_in(6, 1);    rd(16'h1018, d); chk("R4 active low driven", d, 0);

        // R5: edge latch and clear
        set_gw(7, 0, 1);
        set_in(7, 1); rd(16'h101C, d); chk("R5 edge set", d, 1);
        set_in(7, 0); rd(16'h101C, d); chk("R5 edge held", d, 1);
        clr(7);       rd(16'h101C, d); chk("R5 edge cleared", d, 0);

        // R8: tie goes to lower ID
        set_prio(10, 12); set_en(10, 1); set_in(10, 1);
        set_prio(20, 12); set_en(20, 1); set_in(20, 1);
        check_all("R8 tie");
        rd(16'h3010, d); chk("R8 lower id wins", (d >> 2) & 255, 10);

        // R6: disabled stronger source ignored
        set_prio(30, 15); set_in(30, 1);
        check_all("R6 disabled");
        rd(16'h3010, d); chk("R6 disabled not chosen", (d >> 2) & 255, 10);

        // R7: reversed ordering
        set_prio(31, 2); set_en(31, 1); set_in(31, 1);
        m_order = 1; wr(16'h3000, 1);
        check_all("R7 reversed");
        rd(16'h3010, d); chk("R7 low value wins", (d >> 2) & 255, 31);
        m_order = 0; wr(16'h3000, 0);

        // R9: strict threshold and current level
        m_thr = 12; wr(16'h3004, 12); settle();
        chk("R9 equal threshold blocks", int'(irq_req), 0);
        m_thr = 11; wr(16'h3004, 11); m_cur = 12; wr(16'h3008, 12); settle();
        chk("R9 equal current level blocks", int'(irq_req), 0);
        m_cur = 0; wr(16'h3008, 0); settle();
        chk("R9 beats both", int'(irq_req), 1);

        // R10: empty capture, then hold
        for (int s = 1; s <= NS; s++) if (m_en[s] != 0) set_en(s, 0);
        check_all("R10 empty");
        set_en(10, 1); settle();
        rd(16'h3010, d); chk("R10 held without capture", (d >> 2) & 255, 0);

        // R11: base field
        m_base = 32'hFFFFFC00; wr(16'h3010, 32'hFFFFFFFF);
        rd(16'h3010, d); chk("R11 base write", d, 32'hFFFFFC00);

        // R12: unused offsets
        wr(16'h0000, 15); rd(16'h0000, d); chk("R12 source 0", d, 0);
        wr(16'h6000, 15); rd(16'h6000, d); chk("R12 page 6", d, 0);
        wr(16'h0100, 15); rd(16'h0100, d); chk("R12 index 64", d, 0);
        wr(16'h0001, 9);  rd(16'h0000, d); chk("R12 misaligned", d, 0);
        check_all("R12 no side effect");

        // Random rounds
        for (int r = 0; r < 60; r++) begin
            for (int k = 0; k < 5; k++) begin
                int s = 1 + $urandom_range(0, 11);
                if ($urandom_range(0, 4) == 0) s = 1 + $urandom_range(0, NS - 1);
                case ($urandom_range(0, 7))
                    0: set_prio(s, $urandom_range(0, 15));
                    1: set_en(s, $urandom_range(0, 1));
                    2: set_gw(s, $urandom_range(0, 1), $urandom_range(0, 1));
                    3, 4: set_in(s, m_in[s] ^ 1);
                    5: clr(s);
                    6: begin m_order = $urandom_range(0, 1); wr(16'h3000, m_order); end
                    default: begin
                        m_thr = $urandom_range(0, 15); wr(16'h3004, m_thr);
                        m_cur = $urandom_range(0, 15); wr(16'h3008, m_cur);
                    end
                endcase
            end
            check_all("R7 R8 R9 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule